// File: doc/BRIEF.md
# Sequential Sign-Magnitude Multiplier

This block multiplies two 32-bit operands over several clock cycles and returns the 64-bit product as a high word and a low word. A caller drives the operands and the arithmetic mode, then pulses `start` for one cycle. The block captures everything on that edge. A single-cycle `done` pulse marks the cycle in which the two result words become valid. The result words keep their value until the next operation completes.

When signed mode is selected, the block converts both operands to their magnitudes and records the sign of the product as the XOR of the two operand signs. It then runs an unsigned shift-and-add loop. The loop inspects the first operand (the multiplier) one bit at a time, starting at the least significant bit. On each set bit it adds the second operand (the multiplicand) into a 64-bit accumulator. The multiplicand is held as a shifted 64-bit pair, and the carry from the low word is added into the high word. The loop ends as soon as an add leaves no set multiplier bits above the current one. A negative product is then formed by inverting both words, incrementing the low word, and incrementing the high word only when the low word wraps to zero. If either operand is zero, the loop is skipped and both words are cleared.

The controller has four states. `ST_IDLE` waits for `start`. From there it goes to `ST_DONE` when an operand is zero, and to `ST_LOOP` otherwise. `ST_LOOP` runs one shift-and-add iteration per cycle and moves to `ST_NEG` on its final add. `ST_NEG` applies the optional negation and loads the result words, then moves to `ST_DONE`. `ST_DONE` raises `done` and returns to `ST_IDLE` on the next edge.

Top module: `seq_mul`

## Requirements
- R1: While reset is held, and at its release, `done` is 0 and `res_hi` and `res_lo` are 0.
- R2: If either operand is zero at the capturing edge, `res_hi` and `res_lo` become 0 and `done` is high in the cycle that follows that edge.
- R3: With `signed_mode`=0, the 64-bit value {`res_hi`,`res_lo`} equals the unsigned product of `op_a` and `op_b`.
- R4: With `signed_mode`=1, {`res_hi`,`res_lo`} equals the two's-complement 64-bit product of the signed operands, and the result is negative exactly when one operand is negative and neither is zero.
- R5: In signed mode, the operand value 0x80000000 is treated as the magnitude 2^31. For example, 0x80000000 times itself gives 0x4000000000000000.
- R6: For nonzero operands, `done` rises on the (k+3)-th rising edge, counting the capturing edge as the first. Here k is the index of the highest set bit of the multiplier magnitude (`op_a`, or its negation when it is negative in signed mode). The loop never runs more than 32 iterations.
- R7: `done` is high for exactly one cycle per operation. `res_hi` and `res_lo` change only on the edge at which `done` rises, and they hold their value at all other times.
- R8: A `start` pulse that arrives while an operation is in progress is ignored. It neither changes that operation's result nor causes another `done` pulse.
- R9: Operands and mode are captured at the `start` edge. Changing `op_a`, `op_b` or `signed_mode` afterwards has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request; captures the operands when idle |
| signed_mode | input | 1 | 1 = signed arithmetic, 0 = unsigned |
| op_a | input | 32 | Multiplier operand |
| op_b | input | 32 | Multiplicand operand |
| res_hi | output | 32 | Upper word of the product |
| res_lo | output | 32 | Lower word of the product |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
Results take a different number of cycles depending on the operands. A zero operand gives `done` one edge after capture. Any other operand pair gives `done` k+3 edges after capture, where k is the top set bit of the multiplier magnitude, so the latency depends on the data. The bench computes that edge count from the operands before each run. It samples on falling edges and counts them from the capture, and it flags `done` arriving at any other count. In every cycle before `done`, it also confirms that the result words still hold the previous product. It then confirms that `done` stays low for several cycles afterwards, which also catches a stray start pulse that was wrongly accepted.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_NEG  = 2'd2,
        ST_DONE = 2'd3
    } mul_state_e;
endpackage

// File: rtl/mul_sign_prep.sv
// Converts operands to magnitudes and derives the product sign.
module mul_sign_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         signed_mode,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg
);
    logic a_neg, b_neg;

    always_comb begin
        a_neg = signed_mode & a[W-1];
        b_neg = signed_mode & b[W-1];
        // The most negative value negates to itself, which reads as 2^(W-1) unsigned.
        mag_a = a_neg ? (~a + 1'b1) : a;
        mag_b = b_neg ? (~b + 1'b1) : b;
        neg   = a_neg ^ b_neg;
    end
endmodule

// File: rtl/mul_step.sv
// One conditional add of the double-word multiplicand into the accumulator.
module mul_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    input  logic [W-1:0] mc_hi,
    input  logic [W-1:0] mc_lo,
    input  logic         add_en,
    output logic [W-1:0] sum_hi,
    output logic [W-1:0] sum_lo
);
    logic [W:0] lo_wide;

    always_comb begin
        lo_wide = {1'b0, acc_lo} + {1'b0, mc_lo};
        if (add_en) begin
            sum_lo = lo_wide[W-1:0];
            sum_hi = acc_hi + mc_hi + {{(W-1){1'b0}}, lo_wide[W]};
        end else begin
            sum_lo = acc_lo;
            sum_hi = acc_hi;
        end
    end
endmodule

// File: rtl/mul_negate.sv
// Optional double-word two's complement built from two single-word increments.
module mul_negate #(
    parameter int W = 32
) (
    input  logic [W-1:0] in_hi,
    input  logic [W-1:0] in_lo,
    input  logic         en,
    output logic [W-1:0] out_hi,
    output logic [W-1:0] out_lo
);
    logic [W-1:0] inv_lo_inc;

    always_comb begin
        inv_lo_inc = ~in_lo + 1'b1;
        if (en) begin
            out_lo = inv_lo_inc;
            out_hi = (inv_lo_inc == '0) ? (~in_hi + 1'b1) : ~in_hi;
        end else begin
            out_lo = in_lo;
            out_hi = in_hi;
        end
    end
endmodule

// File: rtl/seq_mul.sv
module seq_mul
    import mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    mul_state_e state_q, state_d;

    logic [W-1:0]  mplier_q;
    logic [W-1:0]  mc_hi_q, mc_lo_q;
    logic [W-1:0]  acc_hi_q, acc_lo_q;
    logic          neg_q;
    logic [W-1:0]  res_hi_q, res_lo_q;
    logic [CW-1:0] iter_q;

    logic [W-1:0]  mag_a, mag_b;
    logic          neg_in;
    logic [W-1:0]  sum_hi, sum_lo;
    logic [W-1:0]  fin_hi, fin_lo;
    logic          zero_in;
    logic          last_add;

    mul_sign_prep #(.W(W)) u_prep (
        .a           (op_a),
        .b           (op_b),
        .signed_mode (signed_mode),
        .mag_a       (mag_a),
        .mag_b       (mag_b),
        .neg         (neg_in)
    );

    mul_step #(.W(W)) u_step (
        .acc_hi (acc_hi_q),
        .acc_lo (acc_lo_q),
        .mc_hi  (mc_hi_q),
        .mc_lo  (mc_lo_q),
        .add_en (mplier_q[0]),
        .sum_hi (sum_hi),
        .sum_lo (sum_lo)
    );

    mul_negate #(.W(W)) u_neg (
        .in_hi  (acc_hi_q),
        .in_lo  (acc_lo_q),
        .en     (neg_q),
        .out_hi (fin_hi),
        .out_lo (fin_lo)
    );

    always_comb begin
        zero_in  = (op_a == '0) || (op_b == '0);
        last_add = mplier_q[0] && (mplier_q[W-1:1] == '0);
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = zero_in ? ST_DONE : ST_LOOP;
            ST_LOOP: if (last_add) state_d = ST_NEG;
            ST_NEG:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mplier_q <= '0;
            mc_hi_q  <= '0;
            mc_lo_q  <= '0;
            acc_hi_q <= '0;
            acc_lo_q <= '0;
            neg_q    <= 1'b0;
            res_hi_q <= '0;
            res_lo_q <= '0;
            iter_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        iter_q <= '0;
                        if (zero_in) begin
                            res_hi_q <= '0;
                            res_lo_q <= '0;
                        end else begin
                            mplier_q <= mag_a;
                            mc_hi_q  <= '0;
                            mc_lo_q  <= mag_b;
                            acc_hi_q <= '0;
                            acc_lo_q <= '0;
                            neg_q    <= neg_in;
                        end
                    end
                end
                ST_LOOP: begin
                    acc_hi_q <= sum_hi;
                    acc_lo_q <= sum_lo;
                    {mc_hi_q, mc_lo_q} <= {mc_hi_q[W-2:0], mc_lo_q, 1'b0};
                    mplier_q <= mplier_q >> 1;
                    iter_q   <= iter_q + 1'b1;
                end
                ST_NEG: begin
                    res_hi_q <= fin_hi;
                    res_lo_q <= fin_lo;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done   = (state_q == ST_DONE);
        res_hi = res_hi_q;
        res_lo = res_lo_q;
    end

    // R7: single-cycle completion pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: result words move only together with the completion pulse
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_hi) && $stable(res_lo)));

    // R2: zero operand short-cuts to a cleared result
    a_r2_zero_short: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && zero_in) |=> (done && res_hi == '0 && res_lo == '0));

    // R6: loop iteration bound
    a_r6_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP) |-> (iter_q < CW'(W)));

    // R8: a busy request cannot restart the operation
    a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP && start && !last_add) |=> (state_q == ST_LOOP));

    // R1: outputs idle while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) a_r1_reset_idle: assert (!done);
    end
endmodule

// File: tb/seq_mul_bench.sv
`timescale 1ns/1ps
module seq_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [31:0] res_hi, res_lo;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [31:0] prev_hi = '0, prev_lo = '0;

    always #2.5 clk = ~clk;

    seq_mul #(.W(32)) u_seq_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .op_a(op_a), .op_b(op_b), .res_hi(res_hi), .res_lo(res_lo), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected <150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int top_bit(input logic [31:0] v);
        int k = 0;
        for (int i = 0; i < 32; i++) if (v[i]) k = i;
        return k;
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit sm, input bit inject);
        logic [63:0] exp;
        logic [31:0] ma;
        int lat, cnt;
        bit seen;
        if (sm) exp = 64'($signed(longint'($signed(a)) * longint'($signed(b))));
        else    exp = {32'b0, a} * {32'b0, b};
        ma = (sm && a[31]) ? (~a + 32'd1) : a;
        lat = (a == 0 || b == 0) ? 1 : top_bit(ma) + 3;
        @(negedge clk);
        op_a = a; op_b = b; signed_mode = sm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: disturb inputs after capture
        op_a = ~a; op_b = b ^ 32'h5A5A_0F0F; signed_mode = ~sm;
        cnt = 1; seen = 0;
        while (!seen && cnt <= 40) begin
            if (done) seen = 1;
            else begin
                // R7: hold previous result until done
                check({res_hi, res_lo} == {prev_hi, prev_lo}, "R7 hold", {res_hi, res_lo}, {prev_hi, prev_lo});
                if (inject && cnt == 2 && lat > 3) start = 1'b1;  // R8 busy request
                @(negedge clk);
                start = 1'b0;
                cnt++;
            end
        end
        check(seen && cnt == lat, (a == 0 || b == 0) ? "R2 latency" : "R6 latency",
              64'(cnt), 64'(lat));
        check({res_hi, res_lo} == exp, (a == 0 || b == 0) ? "R2 result" :
              (sm ? "R4 R5 R9 signed result" : "R3 R9 unsigned result"), {res_hi, res_lo}, exp);
        prev_hi = res_hi; prev_lo = res_lo;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check(!done, inject ? "R8 no extra done" : "R7 single pulse", 64'(done), 64'd0);
        end
    endtask

    logic [31:0] pats [12];
    logic [31:0] lf;

    initial begin
        pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001; pats[2] = 32'h0000_0002;
        pats[3] = 32'h0000_0003; pats[4] = 32'h7FFF_FFFF; pats[5] = 32'h8000_0000;
        pats[6] = 32'hFFFF_FFFF; pats[7] = 32'h1234_5678; pats[8] = 32'hFFFF_FFFB;
        pats[9] = 32'h0001_0000; pats[10] = 32'hC000_0001; pats[11] = 32'h0000_8000;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1 done", 64'(done), 64'd0);
        check({res_hi, res_lo} == 64'd0, "R1 result", {res_hi, res_lo}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && {res_hi, res_lo} == 64'd0, "R1 after release", {res_hi, res_lo}, 64'd0);
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    run_op(pats[i], pats[j], m[0], ((i + j) % 3) == 0);
        // R5: most negative operand squared
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);
        check({res_hi, res_lo} == 64'h4000_0000_0000_0000, "R5 min squared",
              {res_hi, res_lo}, 64'h4000_0000_0000_0000);
        lf = 32'hACE1_1234;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            run_op(lf, {lf[15:0], lf[31:16]} ^ 32'h9E37_79B9, n[0], n[2]);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule